// File: doc/BRIEF.md
# BCD Calendar with Shadow Registers

This block keeps wall-clock time and a calendar date in packed BCD. A sub-second down-counter is decremented by a prescaled tick enable supplied from outside. When it reaches zero it reloads from a programmable prescaler value and advances the calendar by one second. The calendar counts seconds, minutes and hours in 24-hour form, then the day of the month, the month, a two-digit year counted from 2000, and a weekday from 1 to 7.

Software reads the calendar through a small register port. By default, reads of the sub-second, time and date words return shadow copies. All three shadows are reloaded together on every prescaled tick, so one read sequence always sees a single instant. A sticky flag tells software that the shadows have been refreshed. Software clears the flag, and the hardware sets it again at the next refresh. A control bit lets reads see the live counters directly. Writes to the time and date words set the live counters.

Top module: `bcd_calendar`

## Requirements
- R1: After reset the registers read as follows: time 0x00000000, date 0x00002101 (the 1st of January 2000, weekday 1), sub-second equal to the reset prescaler value PRE_RST, status 0, prescaler PRE_RST and control 0.
- R2: The time word holds seconds units in [3:0], seconds tens in [6:4], minutes units in [11:8], minutes tens in [14:12], hours units in [19:16] and hours tens in [21:20]. Each second carries 59 s into the minutes, 59 min into the hours, and 23:59:59 to 00:00:00 with a carry into the date. Bit 22 always reads 0, and a write to bit 22 is ignored.
- R3: The date word holds day units in [3:0], day tens in [5:4], month units in [11:8], month tens in bit 12, weekday in [15:13], year units in [19:16] and year tens in [23:20]. The day wraps to 01 after the last day of the month. The month lengths are 31/28/31/30/31/30/31/31/30/31/30/31, and February has 29 days when the value 2000+year is a leap year. December wraps to January and increments the year, and the year wraps from 99 to 00.
- R4: The weekday advances with every day carry and runs 1..7, with 7 wrapping to 1.
- R5: The sub-second counter is 16 bits wide. On each cycle with tick_en high, a non-zero counter decrements by one. A zero counter instead reloads the prescaler value and advances the time by one second. Without tick_en the counter holds. The elapsed fraction of the second is therefore (P − SS)/(P + 1).
- R6: The prescaler register (offset 0x10) holds a 15-bit value in [14:0], and its upper bits read as 0. Writing the prescaler register reloads the sub-second counter with the written value. Writing the time word reloads the counter with the current prescaler value.
- R7: The shadow copies of the sub-second, time and date words are all loaded in the same clock edge as each tick_en cycle, from the counter values that result from that edge. Without tick_en the shadows keep their values, so a write to the live counters does not show in the shadows.
- R8: The sync flag is bit 5 of the status register (offset 0x0C). Hardware sets it on every shadow refresh. A write with bit 5 = 0 clears it. A write with bit 5 = 1 has no effect. When a clearing write and a refresh fall in the same cycle, the set wins.
- R9: The bypass bit is bit 5 of the control register (offset 0x18). While it is set, reads of the time (0x00), date (0x04) and sub-second (0x08) words return the live counters instead of the shadows.
- R10: Reads of any other offset return 0, and the unused bits of the status and control registers read as 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | Prescaled tick enable, one cycle per sub-second step |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Register byte offset |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |

## Verification
A wrong carry or month-length decision shows up as a wrong time or date word one tick after the boundary is crossed. The vector table therefore starts each case one second before a rollover and reads the result immediately after that single tick. A shadow that loads late, or loads out of step with the others, is exposed by reading the shadows after a write with no tick, and again after a tick across midnight. Stale shadows show the old value, and a torn load shows a date that disagrees with the time. A sync flag with the wrong priority reads wrong in the very next cycle after a clear that coincides with a tick.

// File: rtl/bcd_cal_pkg.sv
package bcd_cal_pkg;

  localparam int unsigned WORD_W   = 32;
  localparam int unsigned SYNC_BIT = 5;
  localparam int unsigned BYP_BIT  = 5;

  localparam logic [7:0] OFS_TIME   = 8'h00;
  localparam logic [7:0] OFS_DATE   = 8'h04;
  localparam logic [7:0] OFS_SUBSEC = 8'h08;
  localparam logic [7:0] OFS_STAT   = 8'h0C;
  localparam logic [7:0] OFS_PRE    = 8'h10;
  localparam logic [7:0] OFS_CTRL   = 8'h18;

  typedef struct packed {
    logic [1:0] hr_t;
    logic [3:0] hr_u;
    logic [2:0] mn_t;
    logic [3:0] mn_u;
    logic [2:0] sc_t;
    logic [3:0] sc_u;
  } hms_t;

  typedef struct packed {
    logic [3:0] yr_t;
    logic [3:0] yr_u;
    logic [2:0] wday;
    logic       mo_t;
    logic [3:0] mo_u;
    logic [1:0] dy_t;
    logic [3:0] dy_u;
  } ymd_t;

  localparam hms_t HMS_RST = '0;
  localparam ymd_t YMD_RST = '{yr_t: 4'd0, yr_u: 4'd0, wday: 3'd1, mo_t: 1'b0,
                               mo_u: 4'd1, dy_t: 2'd0, dy_u: 4'd1};

  function automatic logic [WORD_W-1:0] hms_pack(input hms_t t);
    logic [WORD_W-1:0] w;
    w        = '0;
    w[3:0]   = t.sc_u;
    w[6:4]   = t.sc_t;
    w[11:8]  = t.mn_u;
    w[14:12] = t.mn_t;
    w[19:16] = t.hr_u;
    w[21:20] = t.hr_t;
    return w;
  endfunction

  function automatic hms_t hms_unpack(input logic [WORD_W-1:0] w);
    hms_t t;
    t.sc_u = w[3:0];
    t.sc_t = w[6:4];
    t.mn_u = w[11:8];
    t.mn_t = w[14:12];
    t.hr_u = w[19:16];
    t.hr_t = w[21:20];
    return t;
  endfunction

  function automatic logic [WORD_W-1:0] ymd_pack(input ymd_t d);
    logic [WORD_W-1:0] w;
    w        = '0;
    w[3:0]   = d.dy_u;
    w[5:4]   = d.dy_t;
    w[11:8]  = d.mo_u;
    w[12]    = d.mo_t;
    w[15:13] = d.wday;
    w[19:16] = d.yr_u;
    w[23:20] = d.yr_t;
    return w;
  endfunction

  function automatic ymd_t ymd_unpack(input logic [WORD_W-1:0] w);
    ymd_t d;
    d.dy_u = w[3:0];
    d.dy_t = w[5:4];
    d.mo_u = w[11:8];
    d.mo_t = w[12];
    d.wday = w[15:13];
    d.yr_u = w[19:16];
    d.yr_t = w[23:20];
    return d;
  endfunction

  function automatic logic [7:0] bcd2bin(input logic [3:0] tens, input logic [3:0] units);
    return (8'(tens) * 8'd10) + 8'(units);
  endfunction

endpackage

// File: rtl/bcd_subsec_ctr.sv
module bcd_subsec_ctr #(
  parameter int unsigned SS_W    = 16,
  parameter int unsigned PRE_W   = 15,
  parameter int unsigned PRE_RST = 255
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_en,
  input  logic             reload,
  input  logic [PRE_W-1:0] reload_val,
  output logic [SS_W-1:0]  ss_q,
  output logic [SS_W-1:0]  ss_d,
  output logic             sec_pulse
);

  logic ss_en;

  assign ss_en = reload | tick_en;

  always_comb begin
    ss_d      = ss_q;
    sec_pulse = 1'b0;
    if (reload) begin
      ss_d = SS_W'(reload_val);
    end else if (tick_en) begin
      if (ss_q == '0) begin
        ss_d      = SS_W'(reload_val);
        sec_pulse = 1'b1;
      end else begin
        ss_d = ss_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ss_q <= SS_W'(PRE_RST);
    end else if (ss_en) begin
      ss_q <= ss_d;
    end
  end

endmodule

// File: rtl/bcd_time_ctr.sv
module bcd_time_ctr
  import bcd_cal_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic adv,
  input  logic ld,
  input  hms_t ld_val,
  output hms_t q,
  output hms_t d,
  output logic day_carry
);

  logic t_en;

  assign t_en = adv | ld;

  always_comb begin
    d         = q;
    day_carry = 1'b0;
    if (ld) begin
      d = ld_val;
    end else if (adv) begin
      if (q.sc_u != 4'd9) begin
        d.sc_u = q.sc_u + 4'd1;
      end else begin
        d.sc_u = 4'd0;
        if (q.sc_t != 3'd5) begin
          d.sc_t = q.sc_t + 3'd1;
        end else begin
          d.sc_t = 3'd0;
          if (q.mn_u != 4'd9) begin
            d.mn_u = q.mn_u + 4'd1;
          end else begin
            d.mn_u = 4'd0;
            if (q.mn_t != 3'd5) begin
              d.mn_t = q.mn_t + 3'd1;
            end else begin
              d.mn_t = 3'd0;
              if (q.hr_t == 2'd2 && q.hr_u == 4'd3) begin
                d.hr_t    = 2'd0;
                d.hr_u    = 4'd0;
                day_carry = 1'b1;
              end else if (q.hr_u == 4'd9) begin
                d.hr_u = 4'd0;
                d.hr_t = q.hr_t + 2'd1;
              end else begin
                d.hr_u = q.hr_u + 4'd1;
              end
            end
          end
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q <= HMS_RST;
    end else if (t_en) begin
      q <= d;
    end
  end

endmodule

// File: rtl/bcd_date_ctr.sv
module bcd_date_ctr
  import bcd_cal_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic adv,
  input  logic ld,
  input  ymd_t ld_val,
  output ymd_t q,
  output ymd_t d
);

  logic       d_en;
  logic [7:0] yr_bin;
  logic [7:0] mo_bin;
  logic       leap;
  logic [7:0] last_bcd;
  logic       last_day;

  assign d_en   = adv | ld;
  assign yr_bin = bcd2bin(q.yr_t, q.yr_u);
  assign mo_bin = bcd2bin({3'b000, q.mo_t}, q.mo_u);
  // years 2000..2099: only 2000 is a century year and it is divisible by 400
  assign leap   = (yr_bin[1:0] == 2'b00);

  always_comb begin
    case (mo_bin)
      8'd2:                      last_bcd = leap ? 8'h29 : 8'h28;
      8'd4, 8'd6, 8'd9, 8'd11:   last_bcd = 8'h30;
      default:                   last_bcd = 8'h31;
    endcase
  end

  assign last_day = ({2'b00, q.dy_t, q.dy_u} == last_bcd);

  always_comb begin
    d = q;
    if (ld) begin
      d = ld_val;
    end else if (adv) begin
      d.wday = (q.wday == 3'd7) ? 3'd1 : q.wday + 3'd1;
      if (!last_day) begin
        if (q.dy_u == 4'd9) begin
          d.dy_u = 4'd0;
          d.dy_t = q.dy_t + 2'd1;
        end else begin
          d.dy_u = q.dy_u + 4'd1;
        end
      end else begin
        d.dy_t = 2'd0;
        d.dy_u = 4'd1;
        if (q.mo_t && q.mo_u == 4'd2) begin
          d.mo_t = 1'b0;
          d.mo_u = 4'd1;
          if (q.yr_u != 4'd9) begin
            d.yr_u = q.yr_u + 4'd1;
          end else begin
            d.yr_u = 4'd0;
            d.yr_t = (q.yr_t == 4'd9) ? 4'd0 : q.yr_t + 4'd1;
          end
        end else if (q.mo_u == 4'd9) begin
          d.mo_t = 1'b1;
          d.mo_u = 4'd0;
        end else begin
          d.mo_u = q.mo_u + 4'd1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q <= YMD_RST;
    end else if (d_en) begin
      q <= d;
    end
  end

endmodule

// File: rtl/bcd_cal_regs.sv
module bcd_cal_regs
  import bcd_cal_pkg::*;
#(
  parameter int unsigned ADDR_W  = 8,
  parameter int unsigned SS_W    = 16,
  parameter int unsigned PRE_W   = 15,
  parameter int unsigned PRE_RST = 255
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [WORD_W-1:0] bus_wdata,
  input  logic [SS_W-1:0]   live_ss,
  input  logic [SS_W-1:0]   next_ss,
  input  logic [WORD_W-1:0] live_time,
  input  logic [WORD_W-1:0] next_time,
  input  logic [WORD_W-1:0] live_date,
  input  logic [WORD_W-1:0] next_date,
  output logic [WORD_W-1:0] bus_rdata,
  output logic              wr_time,
  output logic              wr_date,
  output logic              wr_pre,
  output logic [PRE_W-1:0]  prediv_q,
  output logic              sync_q,
  output logic              bypass_q,
  output logic [SS_W-1:0]   sh_ss,
  output logic [WORD_W-1:0] sh_time,
  output logic [WORD_W-1:0] sh_date
);

  logic sel_time, sel_date, sel_ss, sel_stat, sel_pre, sel_ctrl;
  logic wr_stat, wr_ctrl;
  logic sync_d;
  logic wdata_unused;

  assign sel_time = (bus_addr == ADDR_W'(OFS_TIME));
  assign sel_date = (bus_addr == ADDR_W'(OFS_DATE));
  assign sel_ss   = (bus_addr == ADDR_W'(OFS_SUBSEC));
  assign sel_stat = (bus_addr == ADDR_W'(OFS_STAT));
  assign sel_pre  = (bus_addr == ADDR_W'(OFS_PRE));
  assign sel_ctrl = (bus_addr == ADDR_W'(OFS_CTRL));

  assign wr_time = bus_we & sel_time;
  assign wr_date = bus_we & sel_date;
  assign wr_pre  = bus_we & sel_pre;
  assign wr_stat = bus_we & sel_stat;
  assign wr_ctrl = bus_we & sel_ctrl;

  assign wdata_unused = ^bus_wdata;

  // hardware refresh outranks a software clear in the same cycle
  always_comb begin
    sync_d = sync_q;
    if (tick_en) begin
      sync_d = 1'b1;
    end else if (wr_stat && !bus_wdata[SYNC_BIT]) begin
      sync_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 1'b0;
    end else begin
      sync_q <= sync_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prediv_q <= PRE_W'(PRE_RST);
    end else if (wr_pre) begin
      prediv_q <= bus_wdata[PRE_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bypass_q <= 1'b0;
    end else if (wr_ctrl) begin
      bypass_q <= bus_wdata[BYP_BIT];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_ss   <= SS_W'(PRE_RST);
      sh_time <= hms_pack(HMS_RST);
      sh_date <= ymd_pack(YMD_RST);
    end else if (tick_en) begin
      sh_ss   <= next_ss;
      sh_time <= next_time;
      sh_date <= next_date;
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (sel_time) begin
      bus_rdata = bypass_q ? live_time : sh_time;
    end else if (sel_date) begin
      bus_rdata = bypass_q ? live_date : sh_date;
    end else if (sel_ss) begin
      bus_rdata = WORD_W'(bypass_q ? live_ss : sh_ss);
    end else if (sel_stat) begin
      bus_rdata[SYNC_BIT] = sync_q;
    end else if (sel_pre) begin
      bus_rdata = WORD_W'(prediv_q);
    end else if (sel_ctrl) begin
      bus_rdata[BYP_BIT] = bypass_q;
    end
  end

endmodule

// File: rtl/bcd_calendar.sv
module bcd_calendar
  import bcd_cal_pkg::*;
#(
  parameter int unsigned ADDR_W  = 8,
  parameter int unsigned SS_W    = 16,
  parameter int unsigned PRE_W   = 15,
  parameter int unsigned PRE_RST = 255
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [WORD_W-1:0] bus_wdata,
  output logic [WORD_W-1:0] bus_rdata
);

  logic              wr_time, wr_date, wr_pre;
  logic [PRE_W-1:0]  prediv_q;
  logic              sync_q, bypass_q;
  logic [SS_W-1:0]   sh_ss;
  logic [WORD_W-1:0] sh_time, sh_date;
  logic              ss_reload;
  logic [PRE_W-1:0]  reload_val;
  logic [SS_W-1:0]   ss_q, ss_d;
  logic              sec_pulse;
  hms_t              hms_q, hms_d;
  logic              day_carry;
  ymd_t              ymd_q, ymd_d;

  assign ss_reload  = wr_pre | wr_time;
  assign reload_val = wr_pre ? bus_wdata[PRE_W-1:0] : prediv_q;

  bcd_subsec_ctr #(
    .SS_W   (SS_W),
    .PRE_W  (PRE_W),
    .PRE_RST(PRE_RST)
  ) u_subsec (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick_en   (tick_en),
    .reload    (ss_reload),
    .reload_val(reload_val),
    .ss_q      (ss_q),
    .ss_d      (ss_d),
    .sec_pulse (sec_pulse)
  );

  bcd_time_ctr u_time (
    .clk      (clk),
    .rst_n    (rst_n),
    .adv      (sec_pulse),
    .ld       (wr_time),
    .ld_val   (hms_unpack(bus_wdata)),
    .q        (hms_q),
    .d        (hms_d),
    .day_carry(day_carry)
  );

  bcd_date_ctr u_date (
    .clk   (clk),
    .rst_n (rst_n),
    .adv   (day_carry),
    .ld    (wr_date),
    .ld_val(ymd_unpack(bus_wdata)),
    .q     (ymd_q),
    .d     (ymd_d)
  );

  bcd_cal_regs #(
    .ADDR_W (ADDR_W),
    .SS_W   (SS_W),
    .PRE_W  (PRE_W),
    .PRE_RST(PRE_RST)
  ) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick_en  (tick_en),
    .bus_we   (bus_we),
    .bus_addr (bus_addr),
    .bus_wdata(bus_wdata),
    .live_ss  (ss_q),
    .next_ss  (ss_d),
    .live_time(hms_pack(hms_q)),
    .next_time(hms_pack(hms_d)),
    .live_date(ymd_pack(ymd_q)),
    .next_date(ymd_pack(ymd_d)),
    .bus_rdata(bus_rdata),
    .wr_time  (wr_time),
    .wr_date  (wr_date),
    .wr_pre   (wr_pre),
    .prediv_q (prediv_q),
    .sync_q   (sync_q),
    .bypass_q (bypass_q),
    .sh_ss    (sh_ss),
    .sh_time  (sh_time),
    .sh_date  (sh_date)
  );

endmodule

// File: rtl/bcd_calendar_chk.sv
module bcd_calendar_chk
  import bcd_cal_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned SS_W   = 16,
  parameter int unsigned PRE_W  = 15
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tick_en,
  input logic              bus_we,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [WORD_W-1:0] bus_wdata,
  input logic [WORD_W-1:0] bus_rdata,
  input logic              ss_reload,
  input logic [SS_W-1:0]   ss_q,
  input logic [PRE_W-1:0]  prediv_q,
  input logic              sync_q,
  input logic [SS_W-1:0]   sh_ss,
  input logic [WORD_W-1:0] sh_time,
  input logic [WORD_W-1:0] sh_date
);

  logic clr_wr;
  assign clr_wr = bus_we && (bus_addr == ADDR_W'(OFS_STAT)) && !bus_wdata[SYNC_BIT];

  assert_sync_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
    tick_en |=> sync_q);

  assert_sync_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_wr && !tick_en) |=> !sync_q);

  assert_sync_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_en && !clr_wr) |=> $stable(sync_q));

  assert_ss_decrement_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_en && !ss_reload && ss_q != '0) |=> (ss_q == SS_W'($past(ss_q) - 1'b1)));

  assert_ss_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_en && !ss_reload) |=> $stable(ss_q));

  assert_ss_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ss_q <= SS_W'(prediv_q));

  assert_shadow_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_en |=> $stable({sh_ss, sh_time, sh_date}));

  assert_no_pm_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == ADDR_W'(OFS_TIME)) |-> !bus_rdata[22]);

endmodule

bind bcd_calendar bcd_calendar_chk #(
  .ADDR_W(ADDR_W),
  .SS_W  (SS_W),
  .PRE_W (PRE_W)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .tick_en  (tick_en),
  .bus_we   (bus_we),
  .bus_addr (bus_addr),
  .bus_wdata(bus_wdata),
  .bus_rdata(bus_rdata),
  .ss_reload(ss_reload),
  .ss_q     (ss_q),
  .prediv_q (prediv_q),
  .sync_q   (sync_q),
  .sh_ss    (sh_ss),
  .sh_time  (sh_time),
  .sh_date  (sh_date)
);

// File: tb/bcd_calendar_tb.sv
module bcd_calendar_tb;

  localparam int unsigned ADDR_W = 8;
  localparam logic [7:0] A_TIME = 8'h00, A_DATE = 8'h04, A_SS = 8'h08,
                         A_STAT = 8'h0C, A_PRE = 8'h10, A_CTRL = 8'h18;

  // {start time, start date, expected time, expected date} after one second
  localparam int NV = 12;
  localparam logic [127:0] VEC [NV] = '{
    {32'h00123456, 32'h0024A315, 32'h00123457, 32'h0024A315},
    {32'h00000009, 32'h0024A315, 32'h00000010, 32'h0024A315},
    {32'h00005959, 32'h0024A315, 32'h00010000, 32'h0024A315},
    {32'h00235959, 32'h00234228, 32'h00000000, 32'h00236301},
    {32'h00235959, 32'h00246228, 32'h00000000, 32'h00248229},
    {32'h00235959, 32'h00248229, 32'h00000000, 32'h0024A301},
    {32'h00235959, 32'h0099F231, 32'h00000000, 32'h00002101},
    {32'h00235959, 32'h0021A430, 32'h00000000, 32'h0021C501},
    {32'h00235959, 32'h0021E131, 32'h00000000, 32'h00212201},
    {32'h00195959, 32'h00218909, 32'h00200000, 32'h00218909},
    {32'h00235959, 32'h00192930, 32'h00000000, 32'h00195001},
    {32'h00235959, 32'h00004228, 32'h00000000, 32'h00006229}
  };

  logic              clk;
  logic              rst_n;
  logic              tick_en;
  logic              bus_we;
  logic [ADDR_W-1:0] bus_addr;
  logic [31:0]       bus_wdata;
  logic [31:0]       bus_rdata;

  int n_chk;
  int n_bad;
  bit done;

  bcd_calendar #(.ADDR_W(ADDR_W), .SS_W(16), .PRE_W(15), .PRE_RST(255)) u_dut (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick_en  (tick_en),
    .bus_we   (bus_we),
    .bus_addr (bus_addr),
    .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] v);
    @(negedge clk);
    bus_addr  = a;
    bus_wdata = v;
    bus_we    = 1'b1;
    @(negedge clk);
    bus_we    = 1'b0;
  endtask

  task automatic wr_tick(input logic [7:0] a, input logic [31:0] v);
    @(negedge clk);
    bus_addr  = a;
    bus_wdata = v;
    bus_we    = 1'b1;
    tick_en   = 1'b1;
    @(negedge clk);
    bus_we    = 1'b0;
    tick_en   = 1'b0;
  endtask

  task automatic tick(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      tick_en = 1'b1;
      @(negedge clk);
      tick_en = 1'b0;
    end
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] v);
    bus_addr = a;
    #1;
    v = bus_rdata;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] v;
    n_chk = 0; n_bad = 0; done = 1'b0;
    rst_n = 1'b0; tick_en = 1'b0; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(A_TIME, v); check("R1 time", v, 32'h00000000);
    rd(A_DATE, v); check("R1 date", v, 32'h00002101);
    rd(A_SS, v);   check("R1 subsec", v, 32'd255);
    rd(A_STAT, v); check("R1 status", v, 32'h0);
    rd(A_PRE, v);  check("R1 prescaler", v, 32'd255);
    rd(A_CTRL, v); check("R1 control", v, 32'h0);
    // R10 unmapped offsets
    rd(8'h14, v);  check("R10 offset 0x14", v, 32'h0);
    rd(8'h1C, v);  check("R10 offset 0x1C", v, 32'h0);

    // vector table: bypass on, prescaler 0 so every tick is a second
    wr(A_CTRL, 32'h20);
    wr(A_PRE, 32'h0);
    for (int i = 0; i < NV; i++) begin
      wr(A_TIME, VEC[i][127:96]);
      wr(A_DATE, VEC[i][95:64]);
      tick(1);
      rd(A_TIME, v); check($sformatf("R2 time vector %0d", i), v, VEC[i][63:32]);
      rd(A_DATE, v); check($sformatf("R3 R4 date vector %0d", i), v, VEC[i][31:0]);
    end

    // R5 sub-second countdown and reload
    wr(A_PRE, 32'd3);
    wr(A_TIME, 32'h0);
    rd(A_SS, v); check("R6 reload on time write", v, 32'd3);
    tick(1);
    rd(A_SS, v); check("R5 decrement", v, 32'd2);
    tick(2);
    rd(A_SS, v); check("R5 reaches zero", v, 32'd0);
    rd(A_TIME, v); check("R5 no second before zero", v, 32'h0);
    tick(1);
    rd(A_SS, v); check("R5 reload at zero", v, 32'd3);
    rd(A_TIME, v); check("R5 second advance", v, 32'h00000001);

    // R6 prescaler width and reload on write
    wr(A_PRE, 32'hFFFFFFFF);
    rd(A_PRE, v); check("R6 prescaler mask", v, 32'h00007FFF);
    rd(A_SS, v);  check("R6 reload on prescaler write", v, 32'h00007FFF);
    wr(A_PRE, 32'd3);

    // R7 / R8 shadows and sync flag
    wr(A_CTRL, 32'h0);
    rd(A_CTRL, v); check("R9 control cleared", v, 32'h0);
    wr(A_STAT, 32'h0);
    rd(A_STAT, v); check("R8 clear by zero write", v, 32'h0);
    wr(A_STAT, 32'h20);
    rd(A_STAT, v); check("R8 one write ignored", v, 32'h0);
    wr(A_TIME, 32'h00101010);
    rd(A_TIME, v); check("R7 shadow stale without tick", v, 32'h00000001);
    tick(1);
    rd(A_STAT, v); check("R8 set on refresh", v, 32'h20);
    rd(A_TIME, v); check("R7 shadow time refreshed", v, 32'h00101010);
    rd(A_SS, v);   check("R7 shadow subsec refreshed", v, 32'd2);
    wr_tick(A_STAT, 32'h0);
    rd(A_STAT, v); check("R8 set wins over clear", v, 32'h20);

    // R7 coherent rollover across midnight
    wr(A_PRE, 32'h0);
    wr(A_TIME, 32'h00235959);
    wr(A_DATE, 32'h0024A315);
    tick(1);
    rd(A_TIME, v); check("R7 coherent time", v, 32'h00000000);
    rd(A_DATE, v); check("R7 coherent date", v, 32'h0024C316);
    rd(A_SS, v);   check("R7 coherent subsec", v, 32'h0);

    // R2 PM bit ignored, R9 bypass shows live counters
    wr(A_CTRL, 32'h20);
    rd(A_CTRL, v); check("R9 control readback", v, 32'h20);
    wr(A_TIME, 32'h00401010);
    rd(A_TIME, v); check("R2 bit 22 ignored", v, 32'h00001010);
    wr(A_TIME, 32'h00070707);
    rd(A_TIME, v); check("R9 live time visible", v, 32'h00070707);
    wr(A_CTRL, 32'h0);
    rd(A_TIME, v); check("R9 shadow when bypass off", v, 32'h00000000);

    finish_run();
  end

endmodule